// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Controller

This block sits between a clocked host and an external 16-bit asynchronous static memory. The host presents one word request at a time on a valid/ready handshake. A request is either a read or a write, and it carries a 19-bit word address and a two-bit byte mask. The controller turns each request into a pin sequence for the memory. The memory pins are an active-low chip enable, an active-high chip enable, output enable, write enable, two byte-lane enables, the address, a data-out bus with its own drive enable, and a data-in bus. When the sequence ends, the controller raises a one-cycle done pulse. For a read, the captured word is valid on the result bus during that pulse.

Every phase is a whole number of clock cycles. Each count comes from nanosecond timing parameters and the clock period, rounded up with a floor of one cycle. The parameters cover:
- address-to-data;
- output-enable-to-data;
- the read and write cycle times;
- write-pulse width;
- address-to-write-end;
- data setup;
- the time the memory takes to release its outputs after write enable falls.

A write ends on the rising edge of write enable. Address, chip enables, byte enables and write data are all held one cycle past that edge.

The state machine has eight states:
- IDLE waits for a request.
- RD_ADDR presents the address with output enable still high.
- RD_WAIT holds output enable low until the data is valid.
- RD_CAPTURE samples the data bus at its closing edge.
- WR_SETUP presents the address with write enable high.
- WR_PULSE holds write enable low.
- WR_RECOVER raises write enable and still drives the data.
- DONE deselects the memory and pulses done.

Transitions:
- IDLE goes to RD_ADDR or WR_SETUP when a request is accepted.
- RD_ADDR goes to RD_WAIT, and RD_WAIT goes to RD_CAPTURE when its timer expires.
- RD_CAPTURE goes to DONE.
- WR_SETUP goes to WR_PULSE, and WR_PULSE goes to WR_RECOVER when its timer expires.
- WR_RECOVER goes to DONE when its timer expires.
- DONE goes back to IDLE.

Top module: `sram_timing_ctrl`

## Requirements
- R1: Out of reset and in IDLE, the memory is parked in standby. This means chip enable low-active pin high, chip enable high-active pin low, both byte enables high, output enable high, write enable high and data drive off. The request ready output is high.
- R2: Ready is high only in IDLE. It drops the cycle after a request is accepted and stays low until done. Done is high for exactly one cycle, and ready is high again on the cycle after it.
- R3: Write enable stays high throughout a read. Output enable is low from the second read cycle until capture. Data is captured at least ceil(T_AA/P) cycles after the address appears and at least ceil(T_DOE/P) cycles after output enable falls. The captured word matches the last data written to that address.
- R4: Mask bit 0 selects data bits 7:0 and drives the low-byte enable pin low. Mask bit 1 selects bits 15:8 and drives the high-byte enable pin low. On a write, only the selected lanes change in memory, and a mask of zero changes nothing. On a read, unselected lanes return zero.
- R5: The write enable low pulse lasts at least ceil(T_PWE/P) cycles. It also lasts at least ceil(T_HZWE/P)+ceil(T_SD/P) cycles.
- R6: Data drive does not start until ceil(T_HZWE/P) cycles after write enable falls. The driven data is stable for at least ceil(T_SD/P) cycles before write enable rises. Drive and data are held for the cycle after write enable rises.
- R7: The address does not change while write enable is low. Chip enables stay asserted when write enable rises, so the write is ended by write enable.
- R8: The controller never drives data while output enable is low, and output enable and write enable are never low together.
- R9: The chip stays selected for at least ceil(T_WC/P) cycles per write and at least ceil(T_RC/P) cycles per read.
- R10: Counted from the acceptance edge, done is observed after exactly 3+W cycles for a read and after exactly 2+PW+RW cycles for a write. The terms are:
  - W = max(1, NAA-2, NDOE-1, NRC-2);
  - PW = max(NPWE, NHZ+NSD, NAW-1);
  - RW = max(1, NWC-1-PW);
  - each N term is a ceiling division of the named time by P, with a floor of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 = low byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data, valid with done |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bhe_n | output | 1 | High byte enable, active low |
| mem_ble_n | output | 1 | Low byte enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A cycle-level memory model returns a marker byte until the address age and output-enable age have both reached their limits. A controller that captures too early therefore returns corrupted read data. At each rising edge of write enable, the model checks four things:
- pulse length;
- data stable time;
- hold of data and address;
- whether chip enables are still asserted.

A shortened pulse, an early data drive or an address that moves mid-pulse each raise a miscompare. Every mask is swept on both writes and reads over a spread of addresses that includes both ends of the space. A wrong lane decode therefore shows up as an altered neighbouring byte or a nonzero unselected lane. Exact done latencies catch any miscounted phase.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_DONE
    } ctrl_state_t;

    // Ceiling division of a time by the clock period, never below one cycle.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*8 +: 8] <= '0;
            end else if (capture) begin
                rdata[g*8 +: 8] <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 45,
    parameter int T_AA_NS       = 45,
    parameter int T_DOE_NS      = 22,
    parameter int T_WC_NS       = 45,
    parameter int T_PWE_NS      = 35,
    parameter int T_AW_NS       = 35,
    parameter int T_SD_NS       = 25,
    parameter int T_HZWE_NS     = 18,
    localparam int LANES        = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_bhe_n,
    output logic              mem_ble_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Phase lengths in cycles
    localparam int N_AA  = ns_to_cycles(T_AA_NS, CLK_PERIOD_NS);
    localparam int N_DOE = ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS);
    localparam int N_RC  = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int N_WC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int N_PWE = ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS);
    localparam int N_AW  = ns_to_cycles(T_AW_NS, CLK_PERIOD_NS);
    localparam int N_SD  = ns_to_cycles(T_SD_NS, CLK_PERIOD_NS);
    localparam int N_HZ  = ns_to_cycles(T_HZWE_NS, CLK_PERIOD_NS);

    localparam int RD_WAIT_LEN = imax(imax(1, N_AA - 2), imax(N_DOE - 1, N_RC - 2));
    localparam int WR_PULSE_LEN = imax(imax(N_PWE, N_HZ + N_SD), N_AW - 1);
    localparam int WR_REC_LEN = imax(1, N_WC - 1 - WR_PULSE_LEN);
    localparam int MAX_LEN = imax(RD_WAIT_LEN, imax(WR_PULSE_LEN, WR_REC_LEN));
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    // Counter value at and below which write data is driven inside the pulse
    localparam int DRIVE_AT = WR_PULSE_LEN - 1 - N_HZ;

    ctrl_state_t state, state_nx;

    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [LANES-1:0]  r_mask;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_count;
    logic             tmr_expired;
    logic             accept;

    assign accept = (state == ST_IDLE) && req_valid;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state == ST_RD_CAPTURE),
        .lane_en (r_mask),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    // Request holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_wdata <= '0;
            r_mask  <= '0;
        end else if (accept) begin
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_mask  <= req_mask;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and phase timer load
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = req_write ? ST_WR_SETUP : ST_RD_ADDR;
            ST_RD_ADDR: begin
                state_nx = ST_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_WAIT_LEN - 1);
            end
            ST_RD_WAIT:    if (tmr_expired) state_nx = ST_RD_CAPTURE;
            ST_RD_CAPTURE: state_nx = ST_DONE;
            ST_WR_SETUP: begin
                state_nx = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_PULSE_LEN - 1);
            end
            ST_WR_PULSE: if (tmr_expired) begin
                state_nx = ST_WR_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_REC_LEN - 1);
            end
            ST_WR_RECOVER: if (tmr_expired) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
        endcase
    end

    // Pin outputs by state
    always_comb begin
        mem_ce1_n = 1'b1;
        mem_ce2   = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_bhe_n = 1'b1;
        mem_ble_n = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_RD_ADDR, ST_WR_SETUP: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_ble_n = ~r_mask[0];
                mem_bhe_n = ~r_mask[LANES-1];
            end
            ST_RD_WAIT, ST_RD_CAPTURE: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_oe_n  = 1'b0;
                mem_ble_n = ~r_mask[0];
                mem_bhe_n = ~r_mask[LANES-1];
            end
            ST_WR_PULSE: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_we_n  = 1'b0;
                mem_ble_n = ~r_mask[0];
                mem_bhe_n = ~r_mask[LANES-1];
                mem_dq_oe = (int'(tmr_count) <= DRIVE_AT);
            end
            ST_WR_RECOVER: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_ble_n = ~r_mask[0];
                mem_bhe_n = ~r_mask[LANES-1];
                mem_dq_oe = 1'b1;
            end
            ST_DONE: rsp_done = 1'b1;
        endcase
    end

    assign mem_addr   = r_addr;
    assign mem_dq_out = r_wdata;

    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_bhe_n && mem_ble_n && !mem_dq_oe)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready)); // R2
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R8
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R8
    AST_PULSE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_PULSE) |-> $stable(mem_addr)); // R7
    AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe); // R6
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce1_n && mem_ce2)); // R6
endmodule

// File: tb/sram_timing_ctrl_tb.sv
module sram_timing_ctrl_tb_top;
    localparam int P = 10;
    localparam int TRC = 45, TAA = 45, TDOE = 22, TWC = 45;
    localparam int TPWE = 35, TAW = 35, TSD = 25, THZ = 18;

    function automatic int cdiv(input int t);
        int c;
        c = (t + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int NAA = cdiv(TAA), NDOE = cdiv(TDOE), NRC = cdiv(TRC), NWC = cdiv(TWC);
    localparam int NPWE = cdiv(TPWE), NAW = cdiv(TAW), NSD = cdiv(TSD), NHZ = cdiv(THZ);
    localparam int RDW = mx(mx(1, NAA - 2), mx(NDOE - 1, NRC - 2));
    localparam int WPL = mx(mx(NPWE, NHZ + NSD), NAW - 1);
    localparam int WRL = mx(1, NWC - 1 - WPL);
    localparam int RD_LAT = 3 + RDW;
    localparam int WR_LAT = 2 + WPL + WRL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_bhe_n, mem_ble_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int vecs = 0;
    int miss = 0;

    always #5 clk = ~clk;

    sram_timing_ctrl #(
        .CLK_PERIOD_NS(P), .T_RC_NS(TRC), .T_AA_NS(TAA), .T_DOE_NS(TDOE),
        .T_WC_NS(TWC), .T_PWE_NS(TPWE), .T_AW_NS(TAW), .T_SD_NS(TSD), .T_HZWE_NS(THZ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bhe_n(mem_bhe_n), .mem_ble_n(mem_ble_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- Timing-checking memory model ----------------
    logic [15:0] mem_store [int];
    logic [15:0] shadow [int];
    bit          p_sel = 0, p_we_n = 1, p_oe = 0, was_wr = 0;
    logic [18:0] p_addr = '0, we_addr = '0;
    logic [15:0] p_out = '0;
    int addr_age = 0, oe_age = 0, we_age = 0, dstab = 0, sel_len = 0;
    int p_we_age = 0, p_dstab = 0;

    always @(negedge clk) begin
        bit sel;
        logic [15:0] cur, nv;
        sel = !mem_ce1_n && mem_ce2;
        if (rst_n) begin
            p_we_age = we_age;
            p_dstab  = dstab;
            if (!sel) addr_age = 0;
            else if (p_sel && mem_addr == p_addr) addr_age++;
            else addr_age = 1;
            oe_age  = (sel && !mem_oe_n) ? oe_age + 1 : 0;
            we_age  = !mem_we_n ? we_age + 1 : 0;
            if (mem_dq_oe && !mem_we_n)
                dstab = (p_oe && mem_dq_out == p_out) ? dstab + 1 : 1;
            else dstab = 0;

            // R8: no data drive against an enabled memory output
            if (mem_dq_oe && !mem_oe_n) chk(0, "R8 drive with OE low", 1, 0);
            if (!mem_oe_n && !mem_we_n) chk(0, "R8 OE and WE both low", 1, 0);
            // R3: WE stays high whenever OE is low during a read
            // R6: no drive before the release time
            if (mem_dq_oe && !mem_we_n && we_age < NHZ + 1)
                chk(0, "R6 early data drive", we_age, NHZ + 1);
            if (!mem_we_n && p_we_n) we_addr = mem_addr;
            if (!mem_we_n && mem_addr != we_addr) chk(0, "R7 address moved in pulse", mem_addr, we_addr);
            if (!mem_we_n) was_wr = 1;

            // Rising edge of WE: write end checks and the write itself
            if (mem_we_n && !p_we_n) begin
                chk(p_we_age >= NPWE && p_we_age >= NHZ + NSD, "R5 WE pulse width", p_we_age, mx(NPWE, NHZ + NSD));
                chk(p_dstab >= NSD, "R6 data setup", p_dstab, NSD);
                chk(mem_dq_oe && mem_dq_out == p_out, "R6 data hold", mem_dq_out, p_out);
                chk(sel && mem_addr == we_addr, "R7 WE-terminated write", mem_addr, we_addr);
                cur = mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)] : 16'h0000;
                nv = cur;
                if (!mem_ble_n) nv[7:0]  = p_out[7:0];
                if (!mem_bhe_n) nv[15:8] = p_out[15:8];
                mem_store[int'(mem_addr)] = nv;
            end

            sel_len = sel ? sel_len + 1 : sel_len;
            if (p_sel && !sel) begin
                chk(sel_len >= (was_wr ? NWC : NRC), "R9 cycle time", sel_len, was_wr ? NWC : NRC);
                sel_len = 0;
                was_wr = 0;
            end

            // Read data lanes: marker bytes when not yet valid or not enabled
            cur = mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)] : 16'h0000;
            for (int l = 0; l < 2; l++) begin
                bit en;
                en = sel && !mem_oe_n && mem_we_n && !(l == 0 ? mem_ble_n : mem_bhe_n);
                if (en) mem_dq_in[l*8 +: 8] = (addr_age >= NAA && oe_age >= NDOE) ? cur[l*8 +: 8] : 8'hE7;
                else    mem_dq_in[l*8 +: 8] = 8'hA5;
            end
        end
        p_sel  = sel;
        p_we_n = mem_we_n;
        p_oe   = mem_dq_oe;
        p_out  = mem_dq_out;
        p_addr = mem_addr;
    end

    // ---------------- Transaction driver ----------------
    task automatic xact(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd);
        int cyc;
        int exp_lat;
        exp_lat = wr ? WR_LAT : RD_LAT;
        @(negedge clk);
        chk(req_ready, "R2 ready in idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        chk(!req_ready, "R2 ready low after accept", req_ready, 0);
        while (!rsp_done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (!rsp_done && req_ready) chk(0, "R2 ready while busy", 1, 0);
        end
        chk(cyc == exp_lat, wr ? "R10 write latency" : "R10 read latency", cyc, exp_lat);
        rd = rsp_rdata;
        @(negedge clk);
        chk(req_ready && !rsp_done, "R2 single done then ready", {req_ready, rsp_done}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miss++;
        vecs++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        logic [15:0] rd, expv, sh;
        logic [18:0] a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: standby under reset
        chk(mem_ce1_n && !mem_ce2 && mem_bhe_n && mem_ble_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 parked in reset", {mem_ce1_n, mem_ce2, mem_bhe_n, mem_ble_n, mem_oe_n, mem_we_n, mem_dq_oe}, 7'b1011110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce1_n && !mem_ce2 && mem_bhe_n && mem_ble_n && !rsp_done,
            "R1 idle after reset", {req_ready, mem_ce1_n, mem_ce2}, 3'b110);

        for (int i = 0; i < 12; i++) begin
            if (i == 0) a = 19'h00000;
            else if (i == 1) a = 19'h7FFFF;
            else a = 19'((i * 32'h2A3B5) ^ (i << 3));
            for (int m = 0; m < 4; m++) begin
                logic [15:0] d;
                d = 16'(a * 7 + m * 16'h1357 + i * 16'h0101 + 16'h3C00);
                xact(1'b1, a, d, 2'(m), rd);
                // R4: only masked lanes change in the expected image
                sh = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
                if (m[0]) sh[7:0]  = d[7:0];
                if (m[1]) sh[15:8] = d[15:8];
                shadow[int'(a)] = sh;
                for (int rm = 0; rm < 4; rm++) begin
                    xact(1'b0, a, 16'h0000, 2'(rm), rd);
                    expv = {rm[1] ? sh[15:8] : 8'h00, rm[0] ? sh[7:0] : 8'h00};
                    chk(rd == expv, rm == 3 ? "R3 read-back word" : "R4 lane-masked read", rd, expv);
                end
            end
        end
        @(negedge clk);
        chk(req_ready && mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n, "R1 parked at end", req_ready, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule